// File: doc/BRIEF.md
# Auto-Ranging Pixel Acquisition Sequencer

This controller scans a two-dimensional sensor array one pixel at a time. It digitises each pixel through an external amplifier chain whose gain can be switched between a low and a maximum setting. A signed offset DAC in front of the last stages takes out the DC level of the signal, so the chain can run at maximum gain without the ADC clipping. The ADC, the DAC and the amplifiers are external. The block talks to them through a start/done pulse pair, a gain-select line, a calibration-select line and a DAC code.

A frame runs in three phases:

1. **Coarse reading.** One conversion is taken at low gain with the DAC at zero. It sets a base DAC code for the whole frame: the reading times a gain ratio, saturated.
2. **Offset reading.** One conversion is taken at maximum gain with the chain input switched to its reference. It captures the chain's own offset.
3. **Pixel scan.** Every pixel is converted at maximum gain, starting from the base code. A reading that sits on an ADC rail moves the DAC code by a fixed step and converts the same pixel again. The number of retries is bounded. Each result is sent out as a word with the offset removed and with the DAC code that produced it.

Top module: `pix_autorange_seq`

## Requirements
- R1: After reset the block idles with `adc_start`, `gain_hi`, `cal_sel`, `word_valid` and `frame_done` low and `dac_code` zero, until `frame_start` is seen.
- R2: The first conversion of a frame runs at low gain (`gain_hi`=0, `cal_sel`=0) with `dac_code`=0 at row 0, column 0.
- R3: The second conversion runs with `gain_hi`=1, `cal_sel`=1 and `dac_code`=0; its result is held as the chain offset.
- R4: Pixels are converted at `gain_hi`=1 in ascending 10-bit address order 0..1023. The row is address bits [9:5] and the column is bits [4:0].
- R5: The base DAC code is the coarse reading times GAIN_RATIO (4), saturated to the signed 12-bit range −2048..2047. Each pixel's first conversion uses the base code.
- R6: `word_sample` is the final 12-bit two's-complement reading minus the held offset, as a 13-bit signed value.
- R7: A pixel reading of 2047 raises the DAC code by DAC_STEP (256), and a reading of −2048 lowers it by DAC_STEP. Both moves saturate to 12 bits, and the same pixel is converted again.
- R8: At most MAX_RETRY (3) extra conversions are made per pixel. If the last one still sits on a rail, the word is sent with `word_ovf`=1 and that reading; otherwise `word_ovf`=0.
- R9: `dac_code` and `gain_hi` stay unchanged for at least `settle_cycles` cycles before each `adc_start`, and `adc_start` is a single-cycle pulse.
- R10: `frame_done` pulses together with the word for address 1023, after which the block returns to idle. `frame_start` is ignored while a frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Begin a frame (idle only) |
| settle_cycles | input | 8 | Settling cycles before each conversion |
| adc_start | output | 1 | Conversion request pulse |
| adc_done | input | 1 | Conversion complete pulse |
| adc_data | input | 12 | Two's-complement ADC result, valid with `adc_done` |
| gain_hi | output | 1 | 1 = maximum gain, 0 = low gain |
| cal_sel | output | 1 | Switch chain input to its reference |
| dac_code | output | 12 | Signed offset DAC code |
| pix_row | output | 5 | Selected row |
| pix_col | output | 5 | Selected column |
| word_valid | output | 1 | Output word strobe |
| word_addr | output | 10 | Address of the word |
| word_sample | output | 13 | Offset-corrected signed sample |
| word_dac | output | 12 | DAC code used for the sample |
| word_ovf | output | 1 | Retry limit reached on a rail |
| frame_done | output | 1 | Last word of the frame |

## Verification
The checker watches, on every cycle:
- the settling window before each conversion request, and the single-cycle shape of the request;
- the gain, calibration and DAC settings of the coarse and offset conversions;
- that the overflow flag agrees with whether the last raw reading sat on a rail;
- that the frame-end pulse coincides with the final address.

The scoreboard covers what only whole frames can show:
- the arithmetic of the base code, its saturation, and the offset subtraction;
- the step-and-retry sequence, including a pixel that recovers on its last allowed retry and one whose DAC code is pinned at full scale;
- scan order, and that a start request in mid-frame changes nothing.

// File: rtl/par_pkg.sv
package par_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_START, ST_WAIT} seq_st_t;
   typedef enum logic [1:0] {PH_COARSE, PH_OFFSET, PH_PIXEL} seq_ph_t;
endpackage

// File: rtl/par_addr_ctr.sv
module par_addr_ctr #(
   parameter int ROW_W = 5,
   parameter int COL_W = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     inc,
   output logic [ROW_W+COL_W-1:0]   addr,
   output logic [ROW_W-1:0]         row,
   output logic [COL_W-1:0]         col,
   output logic                     last
);
   localparam int AW = ROW_W + COL_W;
   logic [AW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) cnt_q <= '0;
      else if (inc)      cnt_q <= cnt_q + 1'b1;
   end

   assign addr = cnt_q;
   assign row  = cnt_q[AW-1:COL_W];
   assign col  = cnt_q[COL_W-1:0];
   assign last = (cnt_q == {AW{1'b1}});
endmodule

// File: rtl/par_settle_tmr.sv
module par_settle_tmr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic [W-1:0] limit,
   output logic         done
);
   logic [W-1:0] cnt_q;

   assign done = run && (cnt_q == limit);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) cnt_q <= '0;
      else if (!done)     cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/par_dac_calc.sv
module par_dac_calc #(
   parameter int ADC_W = 12,
   parameter int DAC_W = 12,
   parameter int RATIO = 4,
   parameter int STEP  = 256
) (
   input  logic signed [ADC_W-1:0] coarse,
   input  logic signed [DAC_W-1:0] cur,
   input  logic                    up,
   output logic signed [DAC_W-1:0] base,
   output logic signed [DAC_W-1:0] stepped
);
   localparam int RW   = $clog2(RATIO + 1) + 1;
   localparam int PW   = (ADC_W + RW > DAC_W + 1) ? ADC_W + RW : DAC_W + 1;
   localparam int DMAXI = (1 << (DAC_W - 1)) - 1;
   localparam int DMINI = -(1 << (DAC_W - 1));
   localparam logic signed [PW-1:0]   PMAX = PW'(DMAXI);
   localparam logic signed [PW-1:0]   PMIN = PW'(DMINI);
   localparam logic signed [DAC_W:0]  SMAX = (DAC_W+1)'(DMAXI);
   localparam logic signed [DAC_W:0]  SMIN = (DAC_W+1)'(DMINI);
   localparam logic signed [DAC_W:0]  STP  = (DAC_W+1)'(STEP);

   logic signed [PW-1:0] cx, prod;
   assign cx = {{(PW-ADC_W){coarse[ADC_W-1]}}, coarse};

   generate
      if ((RATIO & (RATIO - 1)) == 0) begin : g_shift
         assign prod = cx <<< $clog2(RATIO);
      end else begin : g_mult
         assign prod = cx * $signed(PW'(RATIO));
      end
   endgenerate

   always_comb begin
      if (prod > PMAX)      base = PMAX[DAC_W-1:0];
      else if (prod < PMIN) base = PMIN[DAC_W-1:0];
      else                  base = prod[DAC_W-1:0];
   end

   logic signed [DAC_W:0] cx2, sum;
   assign cx2 = {cur[DAC_W-1], cur};
   assign sum = up ? (cx2 + STP) : (cx2 - STP);

   always_comb begin
      if (sum > SMAX)      stepped = SMAX[DAC_W-1:0];
      else if (sum < SMIN) stepped = SMIN[DAC_W-1:0];
      else                 stepped = sum[DAC_W-1:0];
   end
endmodule

// File: rtl/pix_autorange_seq.sv
module pix_autorange_seq import par_pkg::*; #(
   parameter int ROW_W      = 5,
   parameter int COL_W      = 5,
   parameter int ADC_W      = 12,
   parameter int DAC_W      = 12,
   parameter int GAIN_RATIO = 4,
   parameter int DAC_STEP   = 256,
   parameter int MAX_RETRY  = 3,
   parameter int SETTLE_W   = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       frame_start,
   input  logic [SETTLE_W-1:0]        settle_cycles,
   output logic                       adc_start,
   input  logic                       adc_done,
   input  logic [ADC_W-1:0]           adc_data,
   output logic                       gain_hi,
   output logic                       cal_sel,
   output logic [DAC_W-1:0]           dac_code,
   output logic [ROW_W-1:0]           pix_row,
   output logic [COL_W-1:0]           pix_col,
   output logic                       word_valid,
   output logic [ROW_W+COL_W-1:0]     word_addr,
   output logic [ADC_W:0]             word_sample,
   output logic [DAC_W-1:0]           word_dac,
   output logic                       word_ovf,
   output logic                       frame_done
);
   localparam int AW    = ROW_W + COL_W;
   localparam int RTY_W = $clog2(MAX_RETRY + 1);
   localparam logic [ADC_W-1:0] RAIL_HI = {1'b0, {(ADC_W-1){1'b1}}};
   localparam logic [ADC_W-1:0] RAIL_LO = {1'b1, {(ADC_W-1){1'b0}}};

   generate
      if (ROW_W < 1 || COL_W < 1)        begin : g_bad_geom  $error("array fields must be non-empty"); end
      if (ADC_W < 2 || DAC_W < 2)        begin : g_bad_width $error("converter widths too small"); end
      if (GAIN_RATIO < 1)                begin : g_bad_ratio $error("gain ratio must be positive"); end
      if (DAC_STEP < 1 || DAC_STEP >= (1 << (DAC_W - 1))) begin : g_bad_step $error("DAC step out of range"); end
      if (MAX_RETRY < 1)                 begin : g_bad_rty   $error("retry limit must be positive"); end
   endgenerate

   seq_st_t st_q;
   seq_ph_t ph_q;
   logic signed [ADC_W-1:0] coarse_q, off_q;
   logic signed [DAC_W-1:0] dac_q, base_w, step_w;
   logic gain_q, cal_q;
   logic [RTY_W-1:0] rty_q;
   logic [AW-1:0] addr_w;
   logic last_w, settle_done;

   logic got, clip_hi, clip_lo, clip, can_retry, do_retry, emit, begin_frame;
   assign got         = (st_q == ST_WAIT) && adc_done;
   assign clip_hi     = (adc_data == RAIL_HI);
   assign clip_lo     = (adc_data == RAIL_LO);
   assign clip        = clip_hi || clip_lo;
   assign can_retry   = (rty_q < RTY_W'(MAX_RETRY));
   assign do_retry    = got && (ph_q == PH_PIXEL) && clip && can_retry;
   assign emit        = got && (ph_q == PH_PIXEL) && !(clip && can_retry);
   assign begin_frame = (st_q == ST_IDLE) && frame_start;

   par_addr_ctr #(.ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .clr(begin_frame), .inc(emit && !last_w),
      .addr(addr_w), .row(pix_row), .col(pix_col), .last(last_w));

   par_settle_tmr #(.W(SETTLE_W)) u_settle (
      .clk(clk), .rst_n(rst_n), .run(st_q == ST_SETTLE),
      .limit(settle_cycles), .done(settle_done));

   par_dac_calc #(.ADC_W(ADC_W), .DAC_W(DAC_W), .RATIO(GAIN_RATIO), .STEP(DAC_STEP)) u_dac (
      .coarse(coarse_q), .cur(dac_q), .up(clip_hi), .base(base_w), .stepped(step_w));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;  ph_q <= PH_COARSE;
         coarse_q <= '0;   off_q <= '0;   dac_q <= '0;
         gain_q <= 1'b0;   cal_q <= 1'b0; rty_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (frame_start) begin
               st_q <= ST_SETTLE; ph_q <= PH_COARSE;
               gain_q <= 1'b0; cal_q <= 1'b0; dac_q <= '0; rty_q <= '0;
            end
            ST_SETTLE: if (settle_done) st_q <= ST_START;
            ST_START:  st_q <= ST_WAIT;
            ST_WAIT: if (adc_done) begin
               case (ph_q)
                  PH_COARSE: begin
                     coarse_q <= adc_data; ph_q <= PH_OFFSET;
                     gain_q <= 1'b1; cal_q <= 1'b1; dac_q <= '0;
                     st_q <= ST_SETTLE;
                  end
                  PH_OFFSET: begin
                     off_q <= adc_data; ph_q <= PH_PIXEL;
                     cal_q <= 1'b0; dac_q <= base_w;
                     st_q <= ST_SETTLE;
                  end
                  default: begin
                     if (do_retry) begin
                        rty_q <= rty_q + 1'b1; dac_q <= step_w;
                        st_q <= ST_SETTLE;
                     end else begin
                        rty_q <= '0;
                        if (last_w) begin
                           st_q <= ST_IDLE; gain_q <= 1'b0; dac_q <= '0;
                        end else begin
                           st_q <= ST_SETTLE; dac_q <= base_w;
                        end
                     end
                  end
               endcase
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_valid <= 1'b0; frame_done <= 1'b0; word_ovf <= 1'b0;
         word_addr <= '0; word_sample <= '0; word_dac <= '0;
      end else begin
         word_valid <= emit;
         frame_done <= emit && last_w;
         if (emit) begin
            word_addr   <= addr_w;
            word_sample <= {adc_data[ADC_W-1], adc_data} - {off_q[ADC_W-1], off_q};
            word_dac    <= dac_q;
            word_ovf    <= clip;
         end
      end
   end

   assign adc_start = (st_q == ST_START);
   assign gain_hi   = gain_q;
   assign cal_sel   = cal_q;
   assign dac_code  = dac_q;
endmodule

// File: rtl/pix_autorange_chk.sv
module pix_autorange_chk #(
   parameter int ROW_W    = 5,
   parameter int COL_W    = 5,
   parameter int ADC_W    = 12,
   parameter int DAC_W    = 12,
   parameter int SETTLE_W = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [SETTLE_W-1:0]    settle_cycles,
   input logic                   adc_start,
   input logic                   adc_done,
   input logic [ADC_W-1:0]       adc_data,
   input logic                   gain_hi,
   input logic                   cal_sel,
   input logic [DAC_W-1:0]       dac_code,
   input logic [ROW_W-1:0]       pix_row,
   input logic [COL_W-1:0]       pix_col,
   input logic                   word_valid,
   input logic [ROW_W+COL_W-1:0] word_addr,
   input logic                   word_ovf,
   input logic                   frame_done
);
   localparam logic [ADC_W-1:0] RAIL_HI = {1'b0, {(ADC_W-1){1'b1}}};
   localparam logic [ADC_W-1:0] RAIL_LO = {1'b1, {(ADC_W-1){1'b0}}};

   logic [SETTLE_W:0] held_q;
   logic [DAC_W-1:0]  prev_dac;
   logic              prev_gain;
   logic [ADC_W-1:0]  raw_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= '0; prev_dac <= '0; prev_gain <= 1'b0; raw_q <= '0;
      end else begin
         prev_dac  <= dac_code;
         prev_gain <= gain_hi;
         if (dac_code != prev_dac || gain_hi != prev_gain) held_q <= '0;
         else if (held_q != {(SETTLE_W+1){1'b1}})          held_q <= held_q + 1'b1;
         if (adc_done) raw_q <= adc_data;
      end
   end

   AST_SETTLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |-> (held_q >= {1'b0, settle_cycles}));                       // R9
   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |=> !adc_start);                                               // R9
   AST_COARSE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_start && !gain_hi) |-> (dac_code == '0 && !cal_sel && pix_row == '0 && pix_col == '0)); // R2
   AST_OFFSET_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_start && cal_sel) |-> (gain_hi && dac_code == '0));                 // R3
   AST_OVF_ON_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && word_ovf) |-> (raw_q == RAIL_HI || raw_q == RAIL_LO));    // R8
   AST_NO_OVF_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && !word_ovf) |-> (raw_q != RAIL_HI && raw_q != RAIL_LO));   // R7
   AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (word_valid && word_addr == '1));                         // R10
endmodule

bind pix_autorange_seq pix_autorange_chk #(
   .ROW_W(ROW_W), .COL_W(COL_W), .ADC_W(ADC_W), .DAC_W(DAC_W), .SETTLE_W(SETTLE_W)
) u_chk (.*);

// File: tb/sim_pix_autorange_seq.sv
module sim_pix_autorange_seq;
   localparam int GR = 4, STEP = 256, MAXR = 3, CH_OFF = 20;
   localparam int VMAX = 2047, VMIN = -2048;

   logic clk = 1'b0, rst_n = 1'b0, frame_start = 1'b0;
   logic [7:0] settle_cycles = 8'd4;
   logic adc_start, adc_done, gain_hi, cal_sel, word_valid, word_ovf, frame_done;
   logic [11:0] adc_data, dac_code, word_dac;
   logic [4:0] pix_row, pix_col;
   logic [9:0] word_addr;
   logic [12:0] word_sample;

   always #5 clk = ~clk;

   pix_autorange_seq u0 (.*);

   typedef struct {int addr; int sample; int dac; bit ovf;} exp_t;
   exp_t q[$];
   int checks = 0, errors = 0, scene_base = 0, fd_cnt = 0, start_cnt = 0, conv_idx = 0;
   int since = 0;
   logic [11:0] prev_dac = '0;
   logic prev_gain = 1'b0;
   bit finished = 0;

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int clampv(int v);
      return (v > VMAX) ? VMAX : (v < VMIN) ? VMIN : v;
   endfunction

   function automatic int scene(int a);
      case (a)
         5:       return scene_base + 600;
         9:       return scene_base + 900;
         17:      return scene_base - 700;
         1023:    return scene_base + 560;
         default: return (a == 0) ? scene_base : scene_base + ((a * 13) % 151) - 75;
      endcase
   endfunction

   // external chain + ADC model
   initial begin
      adc_done = 1'b0; adc_data = '0;
      forever begin
         @(negedge clk);
         adc_done = 1'b0;
         if (adc_start) begin
            automatic bit g = gain_hi;
            automatic bit c = cal_sel;
            automatic int d = $signed(dac_code);
            automatic int sc = c ? 0 : scene({pix_row, pix_col});
            automatic int v = (g ? GR * sc + CH_OFF : sc) - d;
            repeat (2) @(negedge clk);
            adc_data = 12'(clampv(v));
            adc_done = 1'b1;
         end
      end
   end

   // monitor: scoreboard, settling window, phase setup, frame end
   always @(negedge clk) begin
      if (rst_n) begin
         if (dac_code != prev_dac || gain_hi != prev_gain) since = 0;
         else since++;
         prev_dac = dac_code; prev_gain = gain_hi;
         if (adc_start) begin
            start_cnt++;
            chk(since >= int'(settle_cycles), "R9 settle window", since, settle_cycles);
            if (conv_idx == 0)
               chk(!gain_hi && !cal_sel && dac_code == 0 && pix_row == 0 && pix_col == 0,
                   "R2 coarse setup", {gain_hi, cal_sel}, 0);
            else if (conv_idx == 1)
               chk(gain_hi && cal_sel && dac_code == 0, "R3 offset setup", {gain_hi, cal_sel}, 3);
            else
               chk(gain_hi && !cal_sel, "R4 pixel gain", {gain_hi, cal_sel}, 2);
            conv_idx++;
         end
         if (word_valid) begin
            if (q.size() == 0) chk(0, "R10 extra word", word_addr, -1);
            else begin
               automatic exp_t e = q.pop_front();
               chk(int'(word_addr) == e.addr, "R4 word address", word_addr, e.addr);
               chk($signed(word_sample) == e.sample, "R6 corrected sample", $signed(word_sample), e.sample);
               chk($signed(word_dac) == e.dac, "R5 R7 word DAC code", $signed(word_dac), e.dac);
               chk(word_ovf == e.ovf, "R8 overflow flag", word_ovf, e.ovf);
            end
         end
         if (frame_done) begin
            fd_cnt++;
            chk(word_valid && word_addr == 10'd1023, "R10 frame_done alignment", word_addr, 1023);
         end
      end
   end

   task automatic run_frame(int base, int settle, bit poke);
      int coarse, offv, bdac, prev_fd, st0;
      scene_base = base;
      settle_cycles = 8'(settle);
      coarse = clampv(scene(0));
      offv = clampv(CH_OFF);
      bdac = GR * coarse;
      if (bdac > VMAX) bdac = VMAX;
      if (bdac < VMIN) bdac = VMIN;
      for (int a = 0; a < 1024; a++) begin
         automatic int d = bdac, r = 0, raw;
         automatic exp_t e;
         forever begin
            raw = clampv(GR * scene(a) + CH_OFF - d);
            if ((raw == VMAX || raw == VMIN) && r < MAXR) begin
               d = (raw == VMAX) ? d + STEP : d - STEP;
               if (d > VMAX) d = VMAX;
               if (d < VMIN) d = VMIN;
               r++;
            end else break;
         end
         e.addr = a; e.sample = raw - offv; e.dac = d; e.ovf = (raw == VMAX || raw == VMIN);
         q.push_back(e);
      end
      prev_fd = fd_cnt;
      conv_idx = 0;
      @(negedge clk); frame_start = 1'b1;
      @(negedge clk); frame_start = 1'b0;
      if (poke) begin
         repeat (3000) @(negedge clk);
         frame_start = 1'b1;       // R10: ignored mid-frame
         @(negedge clk); frame_start = 1'b0;
      end
      while (fd_cnt == prev_fd) @(negedge clk);
      st0 = start_cnt;
      repeat (30) @(negedge clk);
      chk(q.size() == 0, "R10 all words delivered", q.size(), 0);
      chk(fd_cnt == prev_fd + 1, "R10 single frame_done", fd_cnt - prev_fd, 1);
      chk(start_cnt == st0, "R10 idle after frame", start_cnt - st0, 0);
      chk(!gain_hi && dac_code == 0, "R1 idle outputs after frame", {gain_hi, dac_code}, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(!adc_start && !word_valid && !frame_done, "R1 reset strobes", {adc_start, word_valid, frame_done}, 0);
      chk(!gain_hi && !cal_sel && dac_code == 0, "R1 reset analog controls", {gain_hi, cal_sel, dac_code}, 0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      chk(start_cnt == 0, "R1 idle without frame_start", start_cnt, 0);
      run_frame(100, 4, 1'b1);   // retries, overflow, low clip
      run_frame(700, 0, 1'b0);   // base saturates at +2047
      run_frame(-300, 9, 1'b0);  // recovery on last retry
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", fd_cnt, 3);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule